// File: doc/BRIEF.md
# Dual-Channel DAC Serial Command Front End

This block is the digital front end of a two-channel, 12-bit voltage-output converter. A host writes 16-bit commands over a three-wire serial link made of an active-low select, a serial clock and a data line. The block brings those three wires into the system clock domain through two-flop synchronizers and finds clock edges there. It collects the bits MSB first. When the select line rises, it applies the command, but only if exactly sixteen bits were captured. A frame may come as one sixteen-bit burst, or as two eight-bit packets with an idle gap between them, as long as the select line stays low for the whole frame.

Each channel is double-buffered. A staging register holds a pending code, and a live register drives the converter code output. Commands can do four things to a channel: stage a code, write the live register directly, write both registers together, or copy both staged codes into their live registers at once. Other commands set the settling-speed mode, the shutdown state and its output-impedance choice, and the two general-purpose output pins.

Two straps are read while reset is held. One picks the serial clock edge used for capture. The other is a three-level power-up pin that sets the starting code of all four channel registers.

Top module: `dual_dac_front`

## Requirements
- R1: A frame is 16 bits, MSB first: bits 15..12 are the command code and bits 11..0 are the data. The frame is applied on the rising edge of `ser_cs_n` only if exactly 16 capture edges occurred while it was low. A frame of 15 or 17 bits leaves every output unchanged.
- R2: `edge_sel_pin` is sampled only while `rst_n` is low. 1 selects capture on rising `ser_clk` edges and 0 selects falling edges. Changing the pin after reset has no effect.
- R3: A frame sent as two 8-bit packets with `ser_clk` idle between them, inside a single low period of `ser_cs_n`, is applied like a continuous frame.
- R4: While in reset, both staging and both live registers load a code set by `pu_level`: 2'b00 gives 0x000, 2'b01 gives 0xFFF, and 2'b10 or 2'b11 (floating) gives 0x800. `slow_settle`, `out_shutdown`, `shdn_100k` and `gpio_out` reset to 0.
- R5: Codes 0x1 and 0x2 write the data into the staging register of channel A or B. The live code outputs do not change.
- R6: Codes 0x3 and 0x4 write the data into both the staging and live registers of channel A or B.
- R7: Code 0x5 copies both staging registers into their live registers in the same cycle.
- R8: Codes 0x9 and 0xA write the data into the live register of channel A or B only. The staging register keeps its value.
- R9: Code 0x6 sets `slow_settle` to data bit 0 (1 = slow, low-power settling).
- R10: Code 0x7 sets `out_shutdown` to data bit 1 and `shdn_100k` to data bit 0 (1 = 100k, 0 = 1k shutdown impedance).
- R11: Code 0x8 sets `gpio_out` to data bits 1..0.
- R12: Codes 0x0 and 0xB through 0xF change no register.
- R13: Live codes and flags change only in the cycle a frame is applied, never while `ser_cs_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are read while it is low |
| ser_clk | input | 1 | Serial clock, asynchronous to clk |
| ser_cs_n | input | 1 | Active-low frame select |
| ser_din | input | 1 | Serial data, MSB first |
| edge_sel_pin | input | 1 | Capture-edge strap (1 rising, 0 falling) |
| pu_level | input | 2 | Power-up level pin: 00 low, 01 high, 1x floating |
| dac_code_a | output | 12 | Live code of channel A |
| dac_code_b | output | 12 | Live code of channel B |
| slow_settle | output | 1 | Settling mode, 1 = slow |
| out_shutdown | output | 1 | Output shutdown request |
| shdn_100k | output | 1 | Shutdown impedance select, 1 = 100k |
| gpio_out | output | 2 | General-purpose output pins |

## Verification
The bench drives every data bit with a decoy value on the edge that should not capture it. A design that sampled the wrong edge, or re-read the strap after reset, therefore loads the complemented word. It sends frames one bit short and one bit long. A design that accepts on a count of at least sixteen, or that wraps its counter, would commit those frames. Staging-only and live-only writes are each followed by a copy command, so a design that touches the wrong register shows a stale code on the live outputs. Unused codes carry an all-ones payload, and split-packet frames are sent in both edge modes and at every power-up level.

// File: rtl/dual_dac_front.sv
module dual_dac_front #(
  parameter int DW = 12,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_clk,
  input  logic          ser_cs_n,
  input  logic          ser_din,
  input  logic          edge_sel_pin,
  input  logic [1:0]    pu_level,
  output logic [DW-1:0] dac_code_a,
  output logic [DW-1:0] dac_code_b,
  output logic          slow_settle,
  output logic          out_shutdown,
  output logic          shdn_100k,
  output logic [1:0]    gpio_out
);
  localparam int FW = DW + CW;
  localparam int NW = $clog2(FW + 2);
  localparam logic [DW-1:0] FULL = '1;
  localparam logic [DW-1:0] ZERO = '0;
  localparam logic [DW-1:0] MID  = {1'b1, {(DW-1){1'b0}}};

  logic [1:0]    sck_m, cs_m, din_m;
  logic          sck_q, cs_q, rise_mode;
  logic [FW-1:0] shreg;
  logic [NW-1:0] cnt;
  logic [DW-1:0] in_a, in_b, dac_a, dac_b;
  logic          slow_r, shdn_r, imp_r;
  logic [1:0]    gpio_r;

  wire          sck_s   = sck_m[1];
  wire          cs_s    = cs_m[1];
  wire          din_s   = din_m[1];
  wire          smp     = rise_mode ? (sck_s & ~sck_q) : (~sck_s & sck_q);
  wire          cs_rise = cs_s & ~cs_q;
  wire          fire    = cs_rise && (cnt == NW'(FW));
  wire [CW-1:0] cmd     = shreg[FW-1 -: CW];
  wire [DW-1:0] dat     = shreg[DW-1:0];
  wire [DW-1:0] pu_code = pu_level[1] ? MID : (pu_level[0] ? FULL : ZERO);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_m <= 2'b00;
      cs_m  <= 2'b11;
      din_m <= 2'b00;
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_m <= {sck_m[0], ser_clk};
      cs_m  <= {cs_m[0], ser_cs_n};
      din_m <= {din_m[0], ser_din};
      sck_q <= sck_s;
      cs_q  <= cs_s;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg     <= '0;
      cnt       <= '0;
      rise_mode <= edge_sel_pin;
    end else if (!cs_s && cs_q) begin
      cnt <= '0;
    end else if (!cs_s && smp) begin
      shreg <= {shreg[FW-2:0], din_s};
      if (cnt != NW'(FW + 1)) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_a   <= pu_code;
      in_b   <= pu_code;
      dac_a  <= pu_code;
      dac_b  <= pu_code;
      slow_r <= 1'b0;
      shdn_r <= 1'b0;
      imp_r  <= 1'b0;
      gpio_r <= 2'b00;
    end else if (fire) begin
      case (cmd)
        CW'(1):  in_a <= dat;
        CW'(2):  in_b <= dat;
        CW'(3):  begin in_a <= dat; dac_a <= dat; end
        CW'(4):  begin in_b <= dat; dac_b <= dat; end
        CW'(5):  begin dac_a <= in_a; dac_b <= in_b; end
        CW'(6):  slow_r <= dat[0];
        CW'(7):  begin shdn_r <= dat[1]; imp_r <= dat[0]; end
        CW'(8):  gpio_r <= dat[1:0];
        CW'(9):  dac_a <= dat;
        CW'(10): dac_b <= dat;
        default: ;
      endcase
    end
  end

  assign dac_code_a   = dac_a;
  assign dac_code_b   = dac_b;
  assign slow_settle  = slow_r;
  assign out_shutdown = shdn_r;
  assign shdn_100k    = imp_r;
  assign gpio_out     = gpio_r;

  a_r13_hold_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_s && !cs_q) |=> ($stable(dac_a) && $stable(dac_b) && $stable(gpio_r)));

  a_r1_commit_after_sixteen: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(dac_a) || !$stable(dac_b)) |-> ($past(cs_rise) && $past(cnt) == NW'(FW)));

  a_r11_gpio_by_code8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gpio_r) |-> ($past(cmd) == CW'(8)));

  a_r12_flags_by_code67: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({slow_r, shdn_r, imp_r}) |-> ($past(cmd) == CW'(6) || $past(cmd) == CW'(7)));

  a_r9_slow_from_d0: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slow_r) |-> $past(shreg[0]));
endmodule

// File: tb/dual_dac_front_test.sv
module dual_dac_front_test;
  logic clk = 0, rst_n = 0, ser_clk = 0, ser_cs_n = 1, ser_din = 0, edge_sel_pin = 1;
  logic [1:0] pu_level = 0;
  logic [11:0] dac_code_a, dac_code_b;
  logic slow_settle, out_shutdown, shdn_100k;
  logic [1:0] gpio_out;

  dual_dac_front uut (.clk, .rst_n, .ser_clk, .ser_cs_n, .ser_din, .edge_sel_pin, .pu_level,
    .dac_code_a, .dac_code_b, .slow_settle, .out_shutdown, .shdn_100k, .gpio_out);

  always #4 clk = ~clk;

  int vecs = 0, bad = 0;
  bit done = 0, mode_rise = 1;
  logic [11:0] ein_a, ein_b, eda, edb;
  logic eslow, eshdn, eimp;
  logic [1:0] egpio;

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic [11:0] act, input logic [11:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, "code_a", dac_code_a, eda);
    chk(req, "code_b", dac_code_b, edb);
    chk(req, "slow", {11'd0, slow_settle}, {11'd0, eslow});
    chk(req, "shdn", {11'd0, out_shutdown}, {11'd0, eshdn});
    chk(req, "imp", {11'd0, shdn_100k}, {11'd0, eimp});
    chk(req, "gpio", {10'd0, gpio_out}, {10'd0, egpio});
  endtask

  task automatic drive_bit(input logic b);
    if (mode_rise) begin
      ser_din = b;  wclk(3); ser_clk = 1; wclk(3);
      ser_din = ~b; wclk(3); ser_clk = 0; wclk(3);
    end else begin
      ser_din = ~b; wclk(3); ser_clk = 1; wclk(3);
      ser_din = b;  wclk(3); ser_clk = 0; wclk(3);
    end
  endtask

  task automatic send(input logic [15:0] w, input int n, input bit split);
    ser_cs_n = 0; wclk(4);
    for (int i = 0; i < n; i++) begin
      drive_bit(i < 16 ? w[15-i] : 1'b0);
      if (split && i == 7) wclk(10);
    end
    ser_cs_n = 1; wclk(7);
  endtask

  task automatic apply(input logic [15:0] w);
    logic [11:0] d = w[11:0];
    case (w[15:12])
      4'h1: ein_a = d;
      4'h2: ein_b = d;
      4'h3: begin ein_a = d; eda = d; end
      4'h4: begin ein_b = d; edb = d; end
      4'h5: begin eda = ein_a; edb = ein_b; end
      4'h6: eslow = d[0];
      4'h7: begin eshdn = d[1]; eimp = d[0]; end
      4'h8: egpio = d[1:0];
      4'h9: eda = d;
      4'hA: edb = d;
      default: ;
    endcase
  endtask

  task automatic frame(input logic [15:0] w, input string req, input bit split = 0);
    send(w, 16, split);
    apply(w);
    check_all(req);
  endtask

  initial begin
    for (int strap = 0; strap < 2; strap++) begin
      for (int pu = 0; pu < 4; pu++) begin
        logic [11:0] p;
        mode_rise = strap[0];
        rst_n = 0; edge_sel_pin = strap[0]; pu_level = pu[1:0];
        ser_clk = 0; ser_cs_n = 1;
        wclk(5); rst_n = 1; wclk(1);
        edge_sel_pin = ~strap[0];
        wclk(3);
        p = pu[1] ? 12'h800 : (pu[0] ? 12'hFFF : 12'h000);
        ein_a = p; ein_b = p; eda = p; edb = p;
        eslow = 0; eshdn = 0; eimp = 0; egpio = 0;
        check_all("R4");
        for (int k = 0; k < 4; k++) begin
          logic [11:0] v = 12'((k * 12'h2A5 + pu * 12'h111 + strap * 12'h0F0) & 12'hFFF);
          frame({4'h1, v}, "R5");
          frame({4'h2, v ^ 12'hFFF}, "R5");
          frame({4'h5, 12'h000}, "R7");
          frame({4'h3, 12'(v + 12'h123)}, "R6");
          frame({4'h4, 12'(v - 12'h321)}, "R6 R3", k[0]);
          frame({4'h9, ~v}, "R8");
          frame({4'hA, 12'(v + 12'h7)}, "R8 R3", k[1]);
          frame({4'h5, 12'hABC}, "R7 R8");
        end
        for (int d = 0; d < 4; d++) begin
          frame({4'h6, 10'h2AA, d[1:0]}, "R9");
          frame({4'h7, 10'h155, d[1:0]}, "R10");
          frame({4'h8, 10'h3FF, d[1:0]}, "R11");
        end
        frame({4'h1, 12'h5A5}, "R5");
        frame({4'h0, 12'hFFF}, "R12");
        for (int c = 11; c < 16; c++) frame({c[3:0], 12'hFFF}, "R12");
        frame({4'h5, 12'h000}, "R7");
        send({4'h3, 12'hABC}, 15, 0); check_all("R1 short");
        send({4'h3, 12'hABC}, 17, 0); check_all("R1 long");
        send({4'h8, 12'h003}, 17, 1); check_all("R1 long split");
        frame({4'h9, 12'h001}, "R1 R2");
        frame({4'hA, 12'h800}, "R1 R2");
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end
endmodule